// File: doc/BRIEF.md
# Daisy-Chain Potentiometer SPI Sequencer

This block is an SPI mode-0 master that writes or reads back one register in each of N digitally controlled potentiometers wired as a daisy chain. All devices share one chip select and one serial clock. The host's MOSI enters device 0, each device's serial output feeds the next device's input, and the serial output of device N-1 comes back to the host as MISO. A user pulses `start` with a read/write select, a 5-bit register address and N data bytes. The sequencer then runs the whole bus transaction and pulses `done` when it has finished.

Each device takes a 16-bit word: an instruction byte (3-bit opcode in the top bits, then the 5-bit address) followed by a data byte, sent MSB first. A write is a single chip-select frame carrying N words. The word for the farthest device goes first, and every device applies its word when chip select rises. A read needs two frames. The first carries N read commands. The second carries N all-zero NOP words, and during that frame each device shifts out a reply whose second byte is the register contents. Clock phases, lead, lag and deselect gaps are counted in system clocks and set by parameters.

The state machine has six states. IDLE waits for a start (launch to LEAD). LEAD holds chip select low before the first clock edge (first edge to SCK_HI). SCK_HI and SCK_LO alternate for every bit (fall and rise). After the last bit, SCK_HI moves to LAG (last fall). LAG raises chip select and moves to GAP (release). GAP keeps chip select high for the deselect time. It then either starts the second read frame (refire to LEAD) or returns to IDLE (retire).

Top module: `chain_pot_seq`

## Requirements
- R1: Out of reset, and whenever no transfer is in progress, `cs_n` is 1, `sck` is 0, `busy` is 0 and `done` is 0.
- R2: Each device word is 16 bits sent MSB first: opcode in bits 15:13, address in bits 12:8, data byte in bits 7:0. The write opcode is 110b, the read opcode is 100b with a data byte of 00h, and a NOP word is 0000h.
- R3: Within a frame, the word for device N-1 is sent first and the word for device 0 last. `wr_data[8k+7:8k]` is the data byte of device k.
- R4: A write uses exactly one chip-select-low frame of 16·N SCK clocks, so all devices apply their words at that frame's single rising edge of `cs_n`.
- R5: A read uses two frames: N read commands, then N NOP words. `rd_data[8k+7:8k]` takes the last 8 bits sampled for word N-1-k of the second frame, which is the data byte of device k.
- R6: SCK idles low (mode 0). Each high phase and each low phase lasts HALF_CYC clocks. MISO is sampled as SCK rises, and MOSI changes only as SCK falls.
- R7: `cs_n` falls LEAD_CYC clocks before the first SCK rise, and rises LAG_CYC clocks after the last SCK fall.
- R8: After every frame, `cs_n` stays high for DESEL_CYC clocks with `busy` still 1, whether another frame follows or not.
- R9: `done` is a one-cycle pulse in the first cycle of `cs_n` high after the final frame. `busy` is 1 from the cycle after an accepted start until the final deselect gap ends.
- R10: `start` is ignored while `busy` is 1. The mode, address and data inputs are used only in the cycle a start is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Transfer request, taken only when idle |
| rd_nwr | input | 1 | 1 = read back, 0 = write |
| addr | input | 5 | Register address placed in every instruction byte |
| wr_data | input | 8·N_DEV | Data byte for device k at bits 8k+7:8k |
| rd_data | output | 8·N_DEV | Read-back byte for device k at bits 8k+7:8k |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| cs_n | output | 1 | Shared active-low chip select |
| sck | output | 1 | Shared serial clock |
| mosi | output | 1 | Serial data to device 0 |
| miso | input | 1 | Serial data from device N-1 |

## Verification
The hardest case to reach from the ports is a read. There, the data seen on MISO comes from commands that the devices latched at the end of the previous frame, and those replies must pass through every downstream device before they reach the host. The bench builds a behavioural chain of N devices, with shift registers and registers updated at each SCK and chip-select edge, and wires it to the bus. A write of distinct bytes followed by a read-back then proves the ordering in both directions. A second start is also pulsed in the middle of a transfer with inverted inputs. The per-cycle reference trace and the device contents must show no effect from it.

// File: rtl/chain_pot_pkg.sv
package chain_pot_pkg;

    localparam int OPC_W  = 3;
    localparam int ADR_W  = 5;
    localparam int BYTE_W = 8;
    localparam int WORD_W = OPC_W + ADR_W + BYTE_W;

    localparam logic [OPC_W-1:0] OPC_WRITE = 3'b110;
    localparam logic [OPC_W-1:0] OPC_READ  = 3'b100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SCK_HI,
        ST_SCK_LO,
        ST_LAG,
        ST_GAP
    } seq_state_t;

endpackage

// File: rtl/chain_pot_timer.sv
module chain_pot_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // A load of len keeps expired low for len-1 cycles; the state then lasts len cycles.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/chain_pot_framer.sv
module chain_pot_framer
    import chain_pot_pkg::*;
#(
    parameter int N_DEV = 3
) (
    input  logic                      rd_nwr,
    input  logic [ADR_W-1:0]          addr,
    input  logic [N_DEV*BYTE_W-1:0]   wr_data,
    output logic [N_DEV*WORD_W-1:0]   frame
);
    // Device k's word sits at bits 16k+15:16k; shifting MSB first sends device N-1 first.
    for (genvar k = 0; k < N_DEV; k++) begin : g_word
        assign frame[k*WORD_W +: WORD_W] = rd_nwr
            ? {OPC_READ,  addr, {BYTE_W{1'b0}}}
            : {OPC_WRITE, addr, wr_data[k*BYTE_W +: BYTE_W]};
    end

endmodule

// File: rtl/chain_pot_seq.sv
module chain_pot_seq
    import chain_pot_pkg::*;
#(
    parameter int N_DEV     = 3,
    parameter int HALF_CYC  = 5,
    parameter int LEAD_CYC  = 13,
    parameter int LAG_CYC   = 13,
    parameter int DESEL_CYC = 100
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     rd_nwr,
    input  logic [4:0]               addr,
    input  logic [N_DEV*8-1:0]       wr_data,
    output logic [N_DEV*8-1:0]       rd_data,
    output logic                     busy,
    output logic                     done,
    output logic                     cs_n,
    output logic                     sck,
    output logic                     mosi,
    input  logic                     miso
);
    localparam int TOT_BITS = N_DEV * WORD_W;
    localparam int BIT_W    = $clog2(TOT_BITS);
    localparam int CNT_W    = $clog2(HALF_CYC + LEAD_CYC + LAG_CYC + DESEL_CYC + 1);
    localparam int WSH      = $clog2(WORD_W);

    seq_state_t state_q, state_d;

    logic [TOT_BITS-1:0] tx_q;
    logic [TOT_BITS-1:0] frame_img;
    logic [BYTE_W-1:0]   rx_q;
    logic [BIT_W-1:0]    bit_q;
    logic                rd_q;
    logic                again_q;
    logic                t_load;
    logic [CNT_W-1:0]    t_len;
    logic                t_exp;
    logic                last_bit;
    logic                word_end;
    int                  cap_dev;

    chain_pot_framer #(.N_DEV(N_DEV)) u_framer (
        .rd_nwr  (rd_nwr),
        .addr    (addr),
        .wr_data (wr_data),
        .frame   (frame_img)
    );

    chain_pot_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (t_load),
        .len     (t_len),
        .expired (t_exp)
    );

    assign last_bit = (bit_q == BIT_W'(TOT_BITS - 1));
    assign word_end = (bit_q[WSH-1:0] == WSH'(WORD_W - 1));
    assign cap_dev  = N_DEV - 1 - int'(bit_q >> WSH);
    assign mosi     = tx_q[TOT_BITS-1];
    assign busy     = (state_q != ST_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions and phase timer loads
    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_len   = '0;
        unique case (state_q)
            ST_IDLE: if (start) begin
                state_d = ST_LEAD;   t_load = 1'b1; t_len = CNT_W'(LEAD_CYC);
            end
            ST_LEAD: if (t_exp) begin
                state_d = ST_SCK_HI; t_load = 1'b1; t_len = CNT_W'(HALF_CYC);
            end
            ST_SCK_HI: if (t_exp) begin
                t_load = 1'b1;
                if (last_bit) begin
                    state_d = ST_LAG;    t_len = CNT_W'(LAG_CYC);
                end else begin
                    state_d = ST_SCK_LO; t_len = CNT_W'(HALF_CYC);
                end
            end
            ST_SCK_LO: if (t_exp) begin
                state_d = ST_SCK_HI; t_load = 1'b1; t_len = CNT_W'(HALF_CYC);
            end
            ST_LAG: if (t_exp) begin
                state_d = ST_GAP;    t_load = 1'b1; t_len = CNT_W'(DESEL_CYC);
            end
            ST_GAP: if (t_exp) begin
                if (again_q) begin
                    state_d = ST_LEAD; t_load = 1'b1; t_len = CNT_W'(LEAD_CYC);
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n    <= 1'b1;
            sck     <= 1'b0;
            done    <= 1'b0;
            tx_q    <= '0;
            rx_q    <= '0;
            bit_q   <= '0;
            rd_q    <= 1'b0;
            again_q <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    cs_n    <= 1'b0;
                    tx_q    <= frame_img;
                    rd_q    <= rd_nwr;
                    again_q <= rd_nwr;
                    bit_q   <= '0;
                end
                ST_LEAD, ST_SCK_LO: if (t_exp) begin
                    sck  <= 1'b1;
                    rx_q <= {rx_q[BYTE_W-2:0], miso};
                end
                ST_SCK_HI: if (t_exp) begin
                    sck <= 1'b0;
                    if (rd_q && !again_q && word_end)
                        rd_data[cap_dev*BYTE_W +: BYTE_W] <= rx_q;
                    if (!last_bit) begin
                        tx_q  <= tx_q << 1;
                        bit_q <= bit_q + 1'b1;
                    end
                end
                ST_LAG: if (t_exp) begin
                    cs_n <= 1'b1;
                    if (again_q) tx_q <= '0;
                    else         done <= 1'b1;
                end
                ST_GAP: if (t_exp && again_q) begin
                    cs_n    <= 1'b0;
                    bit_q   <= '0;
                    again_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // R1: no clock activity while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (cs_n && !sck));

    // R6: data to the chain never moves during a high phase
    a_r6_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

    // R6: clock pulses only inside a selected frame
    a_r6_sck_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !cs_n);

    // R9: completion marks the deselect edge and lasts one cycle
    a_r9_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !$past(cs_n)));
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: an accepted start makes the block busy
    a_r9_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

endmodule

// File: tb/sim_chain_pot_seq.sv
module sim_chain_pot_seq;
    localparam int N     = 3;
    localparam int HALF  = 5;
    localparam int LEAD  = 13;
    localparam int LAG   = 13;
    localparam int DESEL = 100;
    localparam int TOT   = N * 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic rd_nwr = 1'b0;
    logic [4:0] addr = '0;
    logic [N*8-1:0] wr_data = '0;
    logic [N*8-1:0] rd_data;
    logic busy, done, cs_n, sck, mosi, miso;

    always #10 clk = ~clk;

    chain_pot_seq #(.N_DEV(N), .HALF_CYC(HALF), .LEAD_CYC(LEAD),
                    .LAG_CYC(LAG), .DESEL_CYC(DESEL)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .busy(busy), .done(done),
        .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso));

    int n_run = 0;
    int n_fail = 0;

    function automatic string tname(input int t);
        case (t)
            1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
            5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
            9: return "R9";  default: return "R10";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp_v, $time);
        end
    endtask

    // ---------------- behavioural device chain ----------------
    logic        ready = 1'b0;
    logic [15:0] sr  [N];
    logic [7:0]  wip [N];
    logic [7:0]  aux [N];
    logic [N-1:0] outb;
    int          cs_rises = 0;

    assign miso = outb[N-1];

    initial begin
        for (int d = 0; d < N; d++) begin
            sr[d] = '0; wip[d] = 8'h40; aux[d] = 8'h00;
        end
        outb = '0;
    end

    always @(negedge cs_n) if (ready)
        for (int d = 0; d < N; d++) outb[d] = sr[d][15];

    always @(posedge sck) if (ready && !cs_n)
        for (int d = N - 1; d >= 0; d--)
            sr[d] = {sr[d][14:0], (d == 0) ? mosi : outb[d-1]};

    always @(negedge sck) if (ready && !cs_n)
        for (int d = 0; d < N; d++) outb[d] = sr[d][15];

    always @(posedge cs_n) if (ready) begin
        cs_rises++;
        for (int d = 0; d < N; d++) begin
            if (sr[d][15:13] == 3'b110) begin
                if (sr[d][12:8] == 5'd0) wip[d] = sr[d][7:0];
                else                     aux[d] = sr[d][7:0];
                sr[d] = '0;
            end else if (sr[d][15:13] == 3'b100) begin
                sr[d] = {3'b111, sr[d][12:8], (sr[d][12:8] == 5'd0) ? wip[d] : aux[d]};
            end else begin
                sr[d] = '0;
            end
        end
    end

    // ---------------- cycle-by-cycle reference trace ----------------
    typedef struct packed {
        logic       cs;
        logic       sk;
        logic       mo;
        logic       mchk;
        logic       dn;
        logic [3:0] tag;
    } exp_t;
    exp_t q[$];

    task automatic push(input logic c, input logic s, input logic m,
                        input logic mc, input logic d, input int t);
        exp_t e;
        e.cs = c; e.sk = s; e.mo = m; e.mchk = mc; e.dn = d; e.tag = 4'(t);
        q.push_back(e);
    endtask

    task automatic push_frame(input logic [TOT-1:0] w, input bit final_f);
        for (int c = 0; c < LEAD; c++) push(0, 0, w[TOT-1], 1, 0, 7);
        for (int i = 0; i < TOT; i++) begin
            for (int c = 0; c < HALF; c++) push(0, 1, w[TOT-1-i], 1, 0, 6);
            if (i < TOT - 1)
                for (int c = 0; c < HALF; c++) push(0, 0, w[TOT-2-i], 1, 0, 6);
        end
        for (int c = 0; c < LAG; c++) push(0, 0, w[0], 1, 0, 7);
        for (int c = 0; c < DESEL; c++) push(1, 0, 0, 0, final_f && c == 0, 8);
    endtask

    always @(negedge clk) if (rst_n && ready) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(cs_n == e.cs, tname(int'(e.tag)), cs_n, e.cs);
            chk(sck == e.sk, tname(int'(e.tag)), sck, e.sk);
            if (e.mchk) chk(mosi == e.mo, "R2", mosi, e.mo);
            chk(done == e.dn, "R9", done, e.dn);
            chk(busy == 1'b1, "R9", busy, 1);
        end else begin
            chk(cs_n == 1'b1 && sck == 1'b0, "R1", {cs_n, sck}, 2);
            chk(busy == 1'b0 && done == 1'b0, "R1", {busy, done}, 0);
        end
    end

    // ---------------- stimulus ----------------
    task automatic xfer(input bit rd, input logic [4:0] a, input logic [N*8-1:0] d,
                        input bit poke);
        logic [TOT-1:0] w;
        for (int k = 0; k < N; k++)
            w[16*k +: 16] = rd ? {3'b100, a, 8'h00} : {3'b110, a, d[8*k +: 8]};
        @(posedge clk); #2;
        start = 1'b1; rd_nwr = rd; addr = a; wr_data = d;
        @(posedge clk); #2;
        start = 1'b0; rd_nwr = ~rd; addr = ~a; wr_data = ~d;
        push_frame(w, !rd);
        if (rd) push_frame('0, 1'b1);
        if (poke) begin
            repeat (200) @(posedge clk);
            #2 start = 1'b1;
            @(posedge clk); #2 start = 1'b0;
        end
        while (q.size() != 0) @(posedge clk);
        @(posedge clk); #2;
    endtask

    initial begin
        int base;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        ready = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(cs_n == 1'b1, "R1", cs_n, 1);
        chk(sck == 1'b0, "R1", sck, 0);
        chk(busy == 1'b0 && done == 1'b0, "R1", {busy, done}, 0);
        chk(rd_data == '0, "R1", rd_data, 0);

        // R5: read before any write returns the mid-scale power-on code
        base = cs_rises;
        xfer(1'b1, 5'd0, '0, 1'b0);
        chk(cs_rises - base == 2, "R5", cs_rises - base, 2);
        for (int k = 0; k < N; k++) chk(rd_data[8*k +: 8] == 8'h40, "R5", rd_data[8*k +: 8], 8'h40);

        // R3/R4: distinct bytes land in the matching device, one frame
        base = cs_rises;
        xfer(1'b0, 5'd0, 24'h332211, 1'b0);
        chk(cs_rises - base == 1, "R4", cs_rises - base, 1);
        for (int k = 0; k < N; k++) chk(wip[k] == 8'h11 * (k + 1), "R3", wip[k], 8'h11 * (k + 1));

        // R5/R3: read back in device order
        xfer(1'b1, 5'd0, '0, 1'b0);
        for (int k = 0; k < N; k++) chk(rd_data[8*k +: 8] == 8'h11 * (k + 1), "R5", rd_data[8*k +: 8], 8'h11 * (k + 1));

        // R10: extra start during a write has no effect
        base = cs_rises;
        xfer(1'b0, 5'd0, 24'h7F0055, 1'b1);
        chk(cs_rises - base == 1, "R10", cs_rises - base, 1);
        chk(wip[0] == 8'h55, "R10", wip[0], 8'h55);
        chk(wip[1] == 8'h00, "R10", wip[1], 8'h00);
        chk(wip[2] == 8'h7F, "R10", wip[2], 8'h7F);

        // R2: other address is carried in the instruction byte
        xfer(1'b0, 5'h10, 24'hC0A040, 1'b0);
        chk(wip[0] == 8'h55, "R2", wip[0], 8'h55);
        xfer(1'b1, 5'h10, '0, 1'b1);
        chk(rd_data == 24'hC0A040, "R5", rd_data, 24'hC0A040);
        xfer(1'b1, 5'd0, '0, 1'b0);
        chk(rd_data == 24'h7F0055, "R5", rd_data, 24'h7F0055);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog busy=%0d exp=0", busy);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule